// File: doc/BRIEF.md
# Select-less Serial Framing Master

This block is a serial master for a three-wire link (clock, data out, data in) that has no select line. A frame is opened and closed by moving the data line while the clock is high. Data rising under a high clock marks the start of a frame. Data falling under a high clock marks its end. Between those two markers, ordinary data bits change only while the clock is low.

A single request carries a bit count, an open flag, a close flag and a half-bit duration in system clock cycles. The request also carries a write buffer. The block latches all of these and then sends the opening marker if it was asked for. It shifts the requested bits out MSB first and collects the returning bits into a read buffer one byte at a time. It then sends the closing marker if it was asked for. At the end it reports completion with a one-cycle pulse. Because the two flags are independent, one long exchange can be split into several requests: the first opens the frame and the last closes it.

Top module: `edge_framed_spi_master`

## Requirements
- R1: After reset, and whenever the block is idle after a request has completed, `sclk_o` and `sdo_o` are both 0. After reset, `busy_o`, `done_o` and every byte of `rd_data_o` are 0.
- R2: A request is accepted on a clock edge where `start_i` is 1 and `busy_o` is 0. All request inputs, including `wr_data_i`, are latched at that edge. A `start_i` pulse while `busy_o` is 1 has no effect.
- R3: The half-bit length H is `half_i`, with any value below 2 taken as 2. Every line phase lasts H cycles. The number of phases is N = 2·open + 2·len + 4·close. `busy_o` is high for exactly N·H+1 cycles after acceptance. `done_o` is high for one cycle, namely the first cycle in which `busy_o` is low again.
- R4: With the open flag set, the clock rises with data at 0. One half bit later, data goes from 0 to 1 while the clock stays high. The clock stays high for a further half bit. This marker is the first clock pulse of the transfer.
- R5: Bit i of the transfer is bit 7−(i mod 8) of byte i/8 of `wr_data_i`, where byte k is `wr_data_i[8k+7:8k]`. Each bit is placed on `sdo_o` in the second cycle of a clock-low half bit and held through the following clock-high half bit. Apart from the R4 and R6 markers, data never changes while the clock is high.
- R6: With the close flag set, after the last bit the clock drops and data goes to 1 while the clock is low. The clock then rises. One half bit later, data drops from 1 to 0 while the clock is high. After one more half bit the clock falls. This marker is the last clock pulse.
- R7: A transfer produces exactly len + open + close clock pulses.
- R8: Each returning bit is sampled from `sdi_i` one system cycle after the clock falls at the end of its high half bit, and is shifted in MSB first. After the 8th, 16th and later bits, byte k of `rd_data_o` (`rd_data_o[8k+7:8k]`) takes the completed byte. A trailing partial byte, and all bytes past the length, keep their old contents. The read buffer is final in the cycle `done_o` is high.
- R9: A length of 0 with both flags set produces only the opening and closing markers: two clock pulses, with busy lasting 6·H+1 cycles.
- R10: A length of 0 with neither flag set produces no clock pulse, a single busy cycle and a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| len_i | input | 9 (LEN_W) | Bits to transfer, 0 to MAX_BITS |
| begin_i | input | 1 | Send the opening marker |
| end_i | input | 1 | Send the closing marker |
| half_i | input | 8 (HALF_W) | Half-bit length in system cycles (minimum 2) |
| wr_data_i | input | 256 (MAX_BITS) | Write buffer, byte k at bits 8k+7:8k |
| sdi_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the slave |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 256 (MAX_BITS) | Read buffer, byte k at bits 8k+7:8k |

## Verification
Each result has a fixed cycle offset from the accepting edge. Clock pulses start at that edge and busy stays high for N·H+1 cycles. Done and the final read byte appear together one cycle after the last phase. A returned bit is due one cycle after the falling clock. The bench samples on the falling system edge. It counts busy cycles and pulses over the whole window, and it checks the done pulse against the cycle in which busy falls. It loads each slave bit on the serial rising edge so that the bit is stable at the sampling cycle. It compares the read buffer only after done, plus a few idle cycles in which a stray request would show up.

// File: rtl/efs_pkg.sv
package efs_pkg;

  // Shortest legal half bit: data moves one cycle after a clock edge.
  localparam int unsigned EFS_MIN_HALF = 2;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SOF_A,   // clock high, data low
    PH_SOF_B,   // clock high, data rises
    PH_BIT_LO,  // clock low, data placed
    PH_BIT_HI,  // clock high, data held
    PH_EOF_A,   // clock low, data to 1
    PH_EOF_B,   // clock high, data 1
    PH_EOF_C,   // clock high, data falls
    PH_EOF_D,   // clock low, data 0
    PH_TAIL     // one cycle for the last sample
  } phase_t;

  function automatic logic phase_clk(phase_t p);
    case (p)
      PH_SOF_A, PH_SOF_B, PH_BIT_HI, PH_EOF_B, PH_EOF_C: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/efs_half_timer.sv
module efs_half_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              first_o,
  output logic              last_o
);

  logic [HALF_W-1:0] cnt;

  assign first_o = run_i && (cnt == '0);
  assign last_o  = run_i && (cnt == half_i - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i || last_o) cnt <= '0;
    else                         cnt <= cnt + HALF_W'(1);
  end

  // R3: a phase never runs past its half-bit length
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt < half_i));

endmodule

// File: rtl/efs_sequencer.sv
module efs_sequencer
  import efs_pkg::*;
#(
  parameter int MAX_BITS = 256,
  parameter int HALF_W   = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1),
  parameter int IDX_W    = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                begin_i,
  input  logic                end_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                ph_first_i,
  input  logic                ph_last_i,
  output logic                run_o,
  output logic [HALF_W-1:0]   half_o,
  output logic                sclk_o,
  output logic                sdo_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                sample_o,
  output logic                clear_o
);

  localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(MAX_BITS);
  localparam logic [HALF_W-1:0] HALF_MIN = HALF_W'(EFS_MIN_HALF);

  phase_t                state, nxt, entry, after_data, after_begin;
  logic [LEN_W-1:0]      len_q, len_c, bit_idx, bit_nx;
  logic                  beg_q, end_q, tgt, cur_bit;
  logic [HALF_W-1:0]     half_c;
  logic [MAX_BITS-1:0]   wr_q;
  logic [IDX_W-1:0]      bit_sel;

  assign len_c   = (len_i > LEN_MAX) ? LEN_MAX : len_i;
  assign half_c  = (half_i < HALF_MIN) ? HALF_MIN : half_i;
  assign bit_nx  = bit_idx + LEN_W'(1);
  // byte-major order, MSB of each byte first
  assign bit_sel = {bit_idx[IDX_W-1:3], ~bit_idx[2:0]};
  assign cur_bit = wr_q[bit_sel];

  assign busy_o = (state != PH_IDLE);
  assign run_o  = (state != PH_IDLE) && (state != PH_TAIL);

  always_comb begin
    after_data  = end_q ? PH_EOF_A : PH_TAIL;
    after_begin = (len_q != '0) ? PH_BIT_LO : after_data;
    if (begin_i)              entry = PH_SOF_A;
    else if (len_c != '0)     entry = PH_BIT_LO;
    else if (end_i)           entry = PH_EOF_A;
    else                      entry = PH_TAIL;
    case (state)
      PH_SOF_A:  nxt = PH_SOF_B;
      PH_SOF_B:  nxt = after_begin;
      PH_BIT_LO: nxt = PH_BIT_HI;
      PH_BIT_HI: nxt = (bit_nx < len_q) ? PH_BIT_LO : after_data;
      PH_EOF_A:  nxt = PH_EOF_B;
      PH_EOF_B:  nxt = PH_EOF_C;
      PH_EOF_C:  nxt = PH_EOF_D;
      PH_EOF_D:  nxt = PH_TAIL;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      PH_SOF_A, PH_EOF_C, PH_EOF_D: tgt = 1'b0;
      PH_SOF_B, PH_EOF_A, PH_EOF_B: tgt = 1'b1;
      PH_BIT_LO, PH_BIT_HI:         tgt = cur_bit;
      default:                      tgt = sdo_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      len_q    <= '0;
      beg_q    <= 1'b0;
      end_q    <= 1'b0;
      half_o   <= HALF_MIN;
      wr_q     <= '0;
      bit_idx  <= '0;
      sclk_o   <= 1'b0;
      sdo_o    <= 1'b0;
      done_o   <= 1'b0;
      sample_o <= 1'b0;
      clear_o  <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      sample_o <= 1'b0;
      clear_o  <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (start_i) begin
            len_q   <= len_c;
            beg_q   <= begin_i;
            end_q   <= end_i;
            half_o  <= half_c;
            wr_q    <= wr_data_i;
            bit_idx <= '0;
            clear_o <= 1'b1;
            state   <= entry;
            sclk_o  <= phase_clk(entry);
          end
        end
        PH_TAIL: begin
          state  <= PH_IDLE;
          sdo_o  <= 1'b0;
          done_o <= 1'b1;
        end
        default: begin
          if (ph_first_i) sdo_o <= tgt;
          if (ph_last_i) begin
            state  <= nxt;
            sclk_o <= phase_clk(nxt);
            if (state == PH_BIT_HI) begin
              sample_o <= 1'b1;
              bit_idx  <= bit_nx;
            end
          end
        end
      endcase
    end
  end

  // R1: clock rests low whenever no transfer is running
  assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !sclk_o);

  // R2: a request during a transfer leaves the latched request alone
  assert_busy_request_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> ($stable(len_q) && $stable(wr_q) && $stable(end_q)));

  // R3: done lasts one cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3: done marks the first idle cycle after busy
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R5: data moves under a high clock only in the framing markers
  assert_high_clock_data_R5: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o) && (sdo_o != $past(sdo_o)))
      |-> (state == PH_SOF_B || state == PH_EOF_C));

endmodule

// File: rtl/efs_capture.sv
module efs_capture #(
  parameter int MAX_BITS = 256,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear_i,
  input  logic                sample_i,
  input  logic                sdi_i,
  output logic [MAX_BITS-1:0] rd_data_o
);

  localparam int BYTES  = MAX_BITS / 8;
  localparam int SLOT_W = LEN_W - 3;

  logic [LEN_W-1:0]  cnt;
  logic [6:0]        shreg;
  logic [7:0]        byte_nx;
  logic [SLOT_W-1:0] slot;
  logic              store;

  assign byte_nx = {shreg, sdi_i};
  assign slot    = cnt[LEN_W-1:3];
  assign store   = sample_i && !clear_i && (cnt[2:0] == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (clear_i) begin
      cnt   <= '0;
    end else if (sample_i) begin
      cnt   <= cnt + LEN_W'(1);
      shreg <= byte_nx[6:0];
    end
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                                 byte_q <= '0;
      else if (store && slot == SLOT_W'(k))    byte_q <= byte_nx;
    end
    assign rd_data_o[8*k +: 8] = byte_q;
  end

  // R8: consecutive samples are at least one low half bit apart
  assert_sample_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    sample_i |=> !sample_i);

endmodule

// File: rtl/edge_framed_spi_master.sv
module edge_framed_spi_master #(
  parameter int MAX_BITS = 256,
  parameter int HALF_W   = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                begin_i,
  input  logic                end_i,
  input  logic [HALF_W-1:0]   half_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                sdi_i,
  output logic                sclk_o,
  output logic                sdo_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [MAX_BITS-1:0] rd_data_o
);

  localparam int IDX_W = $clog2(MAX_BITS);

  logic              run, ph_first, ph_last, sample, clear;
  logic [HALF_W-1:0] half_q;

  efs_sequencer #(
    .MAX_BITS(MAX_BITS), .HALF_W(HALF_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .begin_i(begin_i), .end_i(end_i), .half_i(half_i), .wr_data_i(wr_data_i),
    .ph_first_i(ph_first), .ph_last_i(ph_last), .run_o(run), .half_o(half_q),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_o(busy_o), .done_o(done_o),
    .sample_o(sample), .clear_o(clear)
  );

  efs_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .half_i(half_q),
    .first_o(ph_first), .last_o(ph_last)
  );

  efs_capture #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_cap (
    .clk(clk), .rst(rst), .clear_i(clear), .sample_i(sample),
    .sdi_i(sdi_i), .rd_data_o(rd_data_o)
  );

endmodule

// File: tb/edge_framed_spi_master_bench.sv
module edge_framed_spi_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_BITS   = 256;
  localparam int HALF_W     = 8;
  localparam int LEN_W      = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                start_i = 1'b0;
  logic [LEN_W-1:0]    len_i = '0;
  logic                begin_i = 1'b0, end_i = 1'b0;
  logic [HALF_W-1:0]   half_i = HALF_W'(2);
  logic [MAX_BITS-1:0] wr_data_i = '0;
  logic                sdi = 1'b0;
  logic                sclk, sdo, busy, done;
  logic [MAX_BITS-1:0] rd_data;

  edge_framed_spi_master u_edge_framed_spi_master (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .begin_i(begin_i),
    .end_i(end_i), .half_i(half_i), .wr_data_i(wr_data_i), .sdi_i(sdi),
    .sclk_o(sclk), .sdo_o(sdo), .busy_o(busy), .done_o(done), .rd_data_o(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input string tag, input logic [MAX_BITS-1:0] act, input logic [MAX_BITS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic pick(input logic [MAX_BITS-1:0] v, input int idx);
    return v[8*(idx/8) + 7 - (idx%8)];
  endfunction

  function automatic logic [MAX_BITS-1:0] rand_vec();
    logic [MAX_BITS-1:0] v;
    for (int w = 0; w < MAX_BITS/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  // Line monitor and slave model
  int t_len = 0, t_beg = 0, t_end = 0;
  logic [MAX_BITS-1:0] t_wr = '0, t_rd = '0, rd_model = '0;
  int mon_epoch = 0, seen_epoch = 0;
  int m_busy = 0, m_done = 0, m_done_bad = 0, m_rise = 0;
  int m_start = 0, m_stop = 0, m_bit_bad = 0, m_order_bad = 0;
  logic p_sclk = 1'b0, p_sdo = 1'b0, p_busy = 1'b0;

  always @(negedge clk) begin
    if (seen_epoch != mon_epoch) begin
      seen_epoch = mon_epoch;
      m_busy = 0; m_done = 0; m_done_bad = 0; m_rise = 0;
      m_start = 0; m_stop = 0; m_bit_bad = 0; m_order_bad = 0;
    end
    if (!rst) begin
      if (busy) m_busy++;
      if (done) begin
        m_done++;
        if (!(p_busy && !busy)) m_done_bad++;
      end
      if (sclk && !p_sclk) begin
        if (m_rise >= t_beg && m_rise < t_beg + t_len) begin
          if (sdo !== pick(t_wr, m_rise - t_beg)) m_bit_bad++;
          sdi = pick(t_rd, m_rise - t_beg);
        end
        m_rise++;
      end else if (sclk && p_sclk && sdo !== p_sdo) begin
        if (sdo) begin
          m_start++;
          if (m_rise != 1) m_order_bad++;
        end else begin
          m_stop++;
          if (m_rise != t_beg + t_len + 1) m_order_bad++;
        end
      end
    end
    p_sclk = sclk; p_sdo = sdo; p_busy = busy;
  end

  int last_busy_exp = 0;

  task automatic xfer(input int len, input int b, input int e, input int half, input bit inject);
    int h, n, guard;
    logic [MAX_BITS-1:0] wv, rv;
    wv = rand_vec();
    rv = rand_vec();
    @(negedge clk);
    t_len = len; t_beg = b; t_end = e; t_wr = wv; t_rd = rv;
    mon_epoch++;
    len_i = LEN_W'(len); begin_i = b[0]; end_i = e[0];
    half_i = HALF_W'(half); wr_data_i = wv; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble inputs after acceptance (R2 latching)
    wr_data_i = rand_vec();
    len_i = LEN_W'($urandom_range(0, 256));
    begin_i = ~begin_i; end_i = ~end_i;
    half_i = HALF_W'($urandom_range(2, 9));
    if (inject) begin
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    guard = 0;
    while (m_done == 0 && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    h = (half < 2) ? 2 : half;
    n = 2*b + 2*len + 4*e;
    last_busy_exp = n*h + 1;
    for (int k = 0; k < len/8; k++) rd_model[8*k +: 8] = rv[8*k +: 8];
    chk("R3 busy cycles", m_busy, n*h + 1);
    chk("R3 done pulses", m_done, 1);
    chk("R3 done in first idle cycle", m_done_bad, 0);
    chk("R7 clock pulses", m_rise, b + len + e);
    chk("R4 start markers", m_start, b);
    chk("R6 stop markers", m_stop, e);
    chk("R5 data bit errors", m_bit_bad, 0);
    chk("R4 and R6 marker placement errors", m_order_bad, 0);
    chk_vec("R8 read buffer", rd_data, rd_model);
    chk("R1 idle clock", sclk, 0);
    chk("R1 idle data", sdo, 0);
  endtask

  initial begin : main
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clock", sclk, 0);
    chk("R1 reset data", sdo, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk_vec("R1 reset read buffer", rd_data, '0);

    xfer(8, 1, 1, 3, 1'b0);
    xfer(0, 1, 1, 2, 1'b0);
    chk("R9 only two marker pulses", m_rise, 2);
    chk("R9 busy length", m_busy, 6*2 + 1);
    xfer(0, 0, 0, 4, 1'b0);
    chk("R10 single busy cycle", m_busy, 1);
    chk("R10 no clock pulses", m_rise, 0);
    xfer(13, 1, 0, 2, 1'b0);
    xfer(7, 0, 1, 3, 1'b0);
    xfer(16, 1, 1, 0, 1'b0);
    xfer(256, 1, 1, 2, 1'b0);
    xfer(21, 1, 1, 3, 1'b1);
    chk("R2 ignored request: done count", m_done, 1);
    chk("R2 ignored request: busy cycles", m_busy, last_busy_exp);

    for (int i = 0; i < 12; i++) begin
      xfer($urandom_range(0, 256), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 5), 1'(i % 3 == 0));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule